// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Interrupt Routing

This block holds two alarm comparators. Each one checks the current BCD time against a set of programmed alarm fields. The check happens only when the one-second time-update strobe is high. Alarm 1 looks at seconds, minutes, hours and a day-or-date field. Alarm 2 looks at minutes, hours and a day-or-date field, and it can only fire when the seconds value is 00.

Each alarm field register carries a mask bit. A masked field counts as a match whatever its value. Setting the mask bits in order from the coarsest field down to the finest gives the repeat rates: every second, every minute, hourly, daily, and once per week or once per month.

A match sets a sticky flag for that alarm. Software clears a flag by writing 0 to it. Two open-drain interrupt pins are modelled as active-high "drive low" enables. A routing bit in a small control register picks one of two arrangements:
- both enabled flags share the first pin, and the second pin carries a square wave supplied from outside; or
- each enabled flag drives its own pin.

The time counter itself sits outside this block. It supplies the current time and the strobe.

Top module: `tod_alarm_unit`

## Requirements
- R1: After reset the control word `ctrl_q` is 000 (bit 2 = routing, bit 1 = alarm 2 enable, bit 0 = alarm 1 enable), both flags are 0, and `pin_a_drive` is 0.
- R2: Alarm flags change to 1 only at a clock edge where `sec_tick` is 1. With `sec_tick` at 0, a time that matches the alarm leaves the flags unchanged.
- R3: Bit 7 of each alarm field register is that field's mask. A masked field always counts as matching, so alarm 1 with all four masks set fires on every tick.
- R4: An unmasked alarm 1 seconds, minutes or hours field matches only when its bits 6..0 equal the current value exactly. For hours, the compare includes bit 6 (12-hour mode) and bit 5 (PM / upper tens), so an alarm coded in the other hour mode never matches.
- R5: In an unmasked day/date field, bit 6 selects the target. With bit 6 = 1, bits 5..0 are compared with the day of week. With bit 6 = 0, bits 5..0 are compared with the date of the month.
- R6: Alarm 2 has no seconds field and needs the current seconds to be 00. With all three masks set it fires once per minute. With only the minutes field unmasked it also needs a minutes match.
- R7: A write to the flags with `flag_wdata` bit i = 0 clears flag i. Bit i = 1 leaves flag i unchanged, so a write can never set a flag. Bit 0 is alarm 1 and bit 1 is alarm 2.
- R8: If a match and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: With routing = 1, `pin_a_drive` = alarm 1 flag AND its enable, and `pin_b_drive` = alarm 2 flag AND its enable.
- R10: With routing = 0, `pin_a_drive` is the OR of both enabled flags, and `pin_b_drive` = NOT `sq_in` (the pin is released when the square wave is high).

Verification hook: when a flag is set and its enable is 1, the matching drive output stays at 1 for as long as both remain set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe marking the once-per-second time update |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours, BCD with mode bit 6 and PM bit 5 |
| cur_day | input | 6 | Current day of week |
| cur_date | input | 6 | Current date of month, BCD |
| a1_sec | input | 8 | Alarm 1 seconds field, bit 7 = mask |
| a1_min | input | 8 | Alarm 1 minutes field, bit 7 = mask |
| a1_hour | input | 8 | Alarm 1 hours field, bit 7 = mask |
| a1_dd | input | 8 | Alarm 1 day/date field, bit 7 = mask, bit 6 = day select |
| a2_min | input | 8 | Alarm 2 minutes field, bit 7 = mask |
| a2_hour | input | 8 | Alarm 2 hours field, bit 7 = mask |
| a2_dd | input | 8 | Alarm 2 day/date field, bit 7 = mask, bit 6 = day select |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 3 | Control write data: bit 2 routing, bit 1 alarm 2 enable, bit 0 alarm 1 enable |
| flag_wr | input | 1 | Write strobe for the flag bits |
| flag_wdata | input | 2 | Flag write data; 0 clears, 1 keeps |
| sq_in | input | 1 | Square wave to place on the second pin |
| ctrl_q | output | 3 | Current control word |
| alarm_flag | output | 2 | Sticky alarm flags, bit 0 alarm 1 |
| pin_a_drive | output | 1 | First interrupt pin pulled low when 1 |
| pin_b_drive | output | 1 | Second pin pulled low when 1 |

## Verification
The alarms are tried against several kinds of time pattern. Field values differ from the alarm by one count, which shows that each unmasked field really takes part in the compare. Hours are given in 12-hour and 24-hour coding, which separates the mode and PM bits from the digits. A day-of-week and a date value are chosen so that only one of them matches, which shows which target bit 6 selects. Seconds of 00 and 01 are used to show the extra seconds condition of alarm 2. The interrupt pins are then checked with each flag and enable pair under both routing settings, with the square wave input toggled.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int AREG_W   = 8;
  localparam int VAL_W    = 7;
  localparam int DD_W     = 6;
  localparam int MASK_BIT = 7;
  localparam int SEL_BIT  = 6;
  localparam int N_ALARM  = 2;
  localparam int CTRL_W   = 3;

  typedef logic [AREG_W-1:0] areg_t;

  typedef struct packed {
    logic route;
    logic en2;
    logic en1;
  } ctrl_t;

  // masked field matches, otherwise exact compare of the value bits
  function automatic logic field_hit(areg_t al, logic [VAL_W-1:0] cur);
    return al[MASK_BIT] | (al[VAL_W-1:0] == cur);
  endfunction

  // day-or-date field: bit 6 picks day of week (1) or date (0)
  function automatic logic dd_hit(areg_t al, logic [DD_W-1:0] day,
                                  logic [DD_W-1:0] date);
    logic [DD_W-1:0] tgt;
    tgt = al[SEL_BIT] ? day : date;
    return al[MASK_BIT] | (al[DD_W-1:0] == tgt);
  endfunction
endpackage

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
(
  input  areg_t            al_sec,
  input  areg_t            al_min,
  input  areg_t            al_hour,
  input  areg_t            al_dd,
  input  logic [VAL_W-1:0] cur_sec,
  input  logic [VAL_W-1:0] cur_min,
  input  logic [VAL_W-1:0] cur_hour,
  input  logic [DD_W-1:0]  cur_day,
  input  logic [DD_W-1:0]  cur_date,
  output logic             hit
);
  logic sec_ok, min_ok, hour_ok, dd_ok;

  always_comb begin
    sec_ok  = field_hit(al_sec, cur_sec);
    min_ok  = field_hit(al_min, cur_min);
    hour_ok = field_hit(al_hour, cur_hour);
    dd_ok   = dd_hit(al_dd, cur_day, cur_date);
    hit     = sec_ok & min_ok & hour_ok & dd_ok;
  end
endmodule

// File: rtl/tod_alarm_flags.sv
module tod_alarm_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (wr_i)     q_o[i] <= q_o[i] & wdata_i[i];
    end
  end
endmodule

// File: rtl/tod_alarm_route.sv
module tod_alarm_route
  import tod_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTRL_W-1:0] ctl_wdata,
  input  logic [N_ALARM-1:0] flag,
  input  logic              sq_in,
  output ctrl_t             ctrl,
  output logic              pin_a,
  output logic              pin_b
);
  logic req1, req2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl <= '0;
    else if (ctl_wr) ctrl <= ctrl_t'(ctl_wdata);
  end

  always_comb begin
    req1 = flag[0] & ctrl.en1;
    req2 = flag[1] & ctrl.en2;
    if (ctrl.route) begin
      pin_a = req1;
      pin_b = req2;
    end else begin
      pin_a = req1 | req2;
      pin_b = ~sq_in;
    end
  end
endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
  import tod_alarm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sec_tick,
  input  logic [VAL_W-1:0]    cur_sec,
  input  logic [VAL_W-1:0]    cur_min,
  input  logic [VAL_W-1:0]    cur_hour,
  input  logic [DD_W-1:0]     cur_day,
  input  logic [DD_W-1:0]     cur_date,
  input  logic [AREG_W-1:0]   a1_sec,
  input  logic [AREG_W-1:0]   a1_min,
  input  logic [AREG_W-1:0]   a1_hour,
  input  logic [AREG_W-1:0]   a1_dd,
  input  logic [AREG_W-1:0]   a2_min,
  input  logic [AREG_W-1:0]   a2_hour,
  input  logic [AREG_W-1:0]   a2_dd,
  input  logic                ctl_wr,
  input  logic [CTRL_W-1:0]   ctl_wdata,
  input  logic                flag_wr,
  input  logic [N_ALARM-1:0]  flag_wdata,
  input  logic                sq_in,
  output logic [CTRL_W-1:0]   ctrl_q,
  output logic [N_ALARM-1:0]  alarm_flag,
  output logic                pin_a_drive,
  output logic                pin_b_drive
);
  areg_t al_sec  [N_ALARM];
  areg_t al_min  [N_ALARM];
  areg_t al_hour [N_ALARM];
  areg_t al_dd   [N_ALARM];

  // named internal events for the checker
  logic [N_ALARM-1:0] alarm_hit;
  logic [N_ALARM-1:0] alarm_event;
  ctrl_t              ctrl;

  // alarm 2 carries a fixed unmasked seconds field of 00
  always_comb begin
    al_sec[0]  = a1_sec;  al_min[0]  = a1_min;
    al_hour[0] = a1_hour; al_dd[0]   = a1_dd;
    al_sec[1]  = '0;      al_min[1]  = a2_min;
    al_hour[1] = a2_hour; al_dd[1]   = a2_dd;
  end

  for (genvar i = 0; i < N_ALARM; i++) begin : g_cmp
    tod_alarm_match u_match (
      .al_sec   (al_sec[i]),
      .al_min   (al_min[i]),
      .al_hour  (al_hour[i]),
      .al_dd    (al_dd[i]),
      .cur_sec  (cur_sec),
      .cur_min  (cur_min),
      .cur_hour (cur_hour),
      .cur_day  (cur_day),
      .cur_date (cur_date),
      .hit      (alarm_hit[i])
    );
  end

  assign alarm_event = alarm_hit & {N_ALARM{sec_tick}};

  tod_alarm_flags #(.N(N_ALARM)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (alarm_event),
    .wr_i    (flag_wr),
    .wdata_i (flag_wdata),
    .q_o     (alarm_flag)
  );

  tod_alarm_route u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .flag      (alarm_flag),
    .sq_in     (sq_in),
    .ctrl      (ctrl),
    .pin_a     (pin_a_drive),
    .pin_b     (pin_b_drive)
  );

  assign ctrl_q = ctrl;
endmodule

// File: rtl/tod_alarm_unit_chk.sv
module tod_alarm_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       flag_wr,
  input logic [1:0] flag_wdata,
  input logic [1:0] alarm_hit,
  input logic [1:0] alarm_flag,
  input logic [2:0] ctrl_q,
  input logic       sq_in,
  input logic       pin_a_drive,
  input logic       pin_b_drive
);
  // R2
  flag0_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> !$rose(alarm_flag[0]));
  // R2
  flag1_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> !$rose(alarm_flag[1]));
  // R8
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && alarm_hit[0]) |=> alarm_flag[0]);
  // R7
  clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !flag_wdata[1] && !(sec_tick && alarm_hit[1])) |=> !alarm_flag[1]);
  // R9
  sep_pin_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[2] && !alarm_flag[1]) |-> !pin_b_drive);
  // R10
  shared_pin_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[2] && sq_in) |-> !pin_b_drive);
  // R10
  no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1:0] == 2'b00) |-> !pin_a_drive);
endmodule

bind tod_alarm_unit tod_alarm_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sec_tick    (sec_tick),
  .flag_wr     (flag_wr),
  .flag_wdata  (flag_wdata),
  .alarm_hit   (alarm_hit),
  .alarm_flag  (alarm_flag),
  .ctrl_q      (ctrl_q),
  .sq_in       (sq_in),
  .pin_a_drive (pin_a_drive),
  .pin_b_drive (pin_b_drive)
);

// File: tb/tod_alarm_unit_test.sv
module tod_alarm_unit_test;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic [6:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
  logic [5:0] cur_day = '0, cur_date = '0;
  logic [7:0] a1_sec = 8'h80, a1_min = 8'h80, a1_hour = 8'h80, a1_dd = 8'h80;
  logic [7:0] a2_min = 8'h80, a2_hour = 8'h80, a2_dd = 8'h80;
  logic ctl_wr = 1'b0;
  logic [2:0] ctl_wdata = '0;
  logic flag_wr = 1'b0;
  logic [1:0] flag_wdata = '0;
  logic sq_in = 1'b0;
  logic [2:0] ctrl_q;
  logic [1:0] alarm_flag;
  logic pin_a_drive, pin_b_drive;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  tod_alarm_unit uut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
  endtask

  task automatic wr_flags(input logic [1:0] v);
    @(negedge clk) begin flag_wr = 1'b1; flag_wdata = v; end
    @(negedge clk) flag_wr = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [2:0] v);
    @(negedge clk) begin ctl_wr = 1'b1; ctl_wdata = v; end
    @(negedge clk) ctl_wr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 ctrl", {5'd0, ctrl_q}, 8'h00);
    check("R1 flags", {6'd0, alarm_flag}, 8'h00);
    check("R1 pin_a", {7'd0, pin_a_drive}, 8'h00);
  endtask

  task automatic t_tick_only();
    // all alarm 1 masks set: matches, but no tick yet
    repeat (3) @(negedge clk);
    check("R2 no tick no flag", {7'd0, alarm_flag[0]}, 8'h00);
    tick();
    check("R3 every second", {7'd0, alarm_flag[0]}, 8'h01);
    wr_flags(2'b00);
  endtask

  task automatic t_seconds();
    a1_sec = 8'h30; cur_sec = 7'h29;
    tick();
    check("R4 sec mismatch", {7'd0, alarm_flag[0]}, 8'h00);
    cur_sec = 7'h30;
    tick();
    check("R4 sec match", {7'd0, alarm_flag[0]}, 8'h01);
    wr_flags(2'b00);
  endtask

  task automatic t_hours();
    a1_min = 8'h15; a1_hour = 8'h08;
    cur_min = 7'h15; cur_hour = 7'h48;  // 8 AM coded 12-hour
    tick();
    check("R4 hour mode differs", {7'd0, alarm_flag[0]}, 8'h00);
    cur_hour = 7'h08; cur_min = 7'h16;
    tick();
    check("R4 minute differs", {7'd0, alarm_flag[0]}, 8'h00);
    cur_min = 7'h15;
    tick();
    check("R4 h/m/s match", {7'd0, alarm_flag[0]}, 8'h01);
    wr_flags(2'b00);
  endtask

  task automatic t_daydate();
    cur_day = 6'd3; cur_date = 6'h15;
    a1_dd = 8'h43;              // day select, day 3
    tick();
    check("R5 day match", {7'd0, alarm_flag[0]}, 8'h01);
    wr_flags(2'b00);
    a1_dd = 8'h03;              // date 03 while date is 15
    tick();
    check("R5 date select ignores day", {7'd0, alarm_flag[0]}, 8'h00);
    a1_dd = 8'h15;
    tick();
    check("R5 date match", {7'd0, alarm_flag[0]}, 8'h01);
    wr_flags(2'b00);
    a1_sec = 8'h80; a1_min = 8'h80; a1_hour = 8'h80; a1_dd = 8'h80;
  endtask

  task automatic t_alarm2();
    cur_sec = 7'h01;
    tick();
    check("R6 per minute, sec 01", {7'd0, alarm_flag[1]}, 8'h00);
    cur_sec = 7'h00;
    tick();
    check("R6 per minute, sec 00", {7'd0, alarm_flag[1]}, 8'h01);
    wr_flags(2'b01);
    check("R7 clear flag 2 keep flag 1", {6'd0, alarm_flag}, 8'h01);
    a2_min = 8'h42; cur_min = 7'h42; cur_sec = 7'h07;
    tick();
    check("R6 minutes, sec not 00", {7'd0, alarm_flag[1]}, 8'h00);
    cur_sec = 7'h00; cur_min = 7'h41;
    tick();
    check("R6 minutes mismatch", {7'd0, alarm_flag[1]}, 8'h00);
    cur_min = 7'h42;
    tick();
    check("R6 minutes match", {7'd0, alarm_flag[1]}, 8'h01);
    a2_min = 8'h80;
  endtask

  task automatic t_flag_write();
    // both flags are 1 now
    wr_flags(2'b11);
    check("R7 write 1 keeps", {6'd0, alarm_flag}, 8'h03);
    wr_flags(2'b00);
    check("R7 write 0 clears", {6'd0, alarm_flag}, 8'h00);
    wr_flags(2'b11);
    check("R7 write 1 never sets", {6'd0, alarm_flag}, 8'h00);
    cur_sec = 7'h05;
    @(negedge clk) begin sec_tick = 1'b1; flag_wr = 1'b1; flag_wdata = 2'b00; end
    @(negedge clk) begin sec_tick = 1'b0; flag_wr = 1'b0; end
    check("R8 set beats clear", {6'd0, alarm_flag}, 8'h01);
  endtask

  task automatic t_route();
    // flag 1 = 1, flag 2 = 0
    check("R10 no enable", {7'd0, pin_a_drive}, 8'h00);
    sq_in = 1'b1; #1;
    check("R10 square high", {7'd0, pin_b_drive}, 8'h00);
    sq_in = 1'b0; #1;
    check("R10 square low", {7'd0, pin_b_drive}, 8'h01);
    wr_ctrl(3'b101);
    check("R9 pin a alarm 1", {7'd0, pin_a_drive}, 8'h01);
    check("R9 pin b idle", {7'd0, pin_b_drive}, 8'h00);
    wr_flags(2'b00);
    cur_sec = 7'h00;
    tick();
    check("R9 flags", {6'd0, alarm_flag}, 8'h03);
    check("R9 pin b masked by enable", {7'd0, pin_b_drive}, 8'h00);
    wr_ctrl(3'b110);
    check("R9 pin a off", {7'd0, pin_a_drive}, 8'h00);
    check("R9 pin b alarm 2", {7'd0, pin_b_drive}, 8'h01);
    wr_ctrl(3'b010);
    sq_in = 1'b1; #1;
    check("R10 alarm 2 on pin a", {7'd0, pin_a_drive}, 8'h01);
    check("R10 pin b is square", {7'd0, pin_b_drive}, 8'h00);
    wr_flags(2'b01);
    check("R10 pin a released", {7'd0, pin_a_drive}, 8'h00);
    check("R10 ctrl readback", {5'd0, ctrl_q}, 8'h02);
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tick_only();
    t_seconds();
    t_hours();
    t_daydate();
    t_alarm2();
    t_flag_write();
    t_route();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule